// File: doc/BRIEF.md
# GPIO Pin Function Select and Output Latch Controller

This block holds the pin-mode configuration and the output levels for a bank of 54 general-purpose pins. Each pin owns a 3-bit mode code that makes it an input, a driven output, or hands it to one of six alternate peripheral functions. The codes are packed ten to a 32-bit word, so six words cover every pin. The block exports the code of every pin, an output enable and an output level to the pad multiplexer that sits next to it.

Output levels are never written directly. Software writes a word of ones to a set word, which raises the latches it selects, or to a clear word, which lowers them. Bits written as zero leave their pins alone, so one pin changes without a read-modify-write sequence and without disturbing pins owned by other code. Each of the set and clear functions has two words, one for pins 0 to 31 and one for pins 32 to 53.

The register port accepts one access per cycle: a write strobe, a read strobe, a word address and write data. Read data is registered.

Top module: `gpio_pinmux_ctrl`

## Requirements
- R1: After reset every mode code is 000 (input), every output enable is 0 and every output latch is 0.
- R2: The mode code of pin p is stored in word p/10 (word addresses 0 to 5), bits 3*(p mod 10)+2 down to 3*(p mod 10), and reads back from that position.
- R3: A pin's output enable is 1 only while its code is 001 (output). Codes 010 to 111 select the six alternate functions, keep the enable at 0 and are passed to the pad multiplexer unchanged.
- R4: Writing a 1 to bit b of set word 6 raises the latch of pin b, and of set word 7 raises the latch of pin 32+b. Bits written as 0 change nothing.
- R5: Writing a 1 to bit b of clear word 8 lowers the latch of pin b, and of clear word 9 lowers the latch of pin 32+b. Bits written as 0 change nothing.
- R6: Reads of the set and clear words (addresses 6 to 9) return zero.
- R7: A latch keeps its level while its pin is an input or an alternate function, and that level is driven again once the pin returns to code 001.
- R8: Bits 31:30 of every mode word and the fields for pins 54 to 59 in word 5 ignore writes and read as zero. Bits 22 to 31 of set word 7 and of clear word 9 have no effect.
- R9: Writes to word addresses 10 and above change no pad output, and reads from them return zero.
- R10: Read data appears on the cycle after the read strobe. A written mode or level reaches the pad outputs on the cycle after the write strobe.
- R11: Writes take effect in the order they are issued, so a clear issued after a set leaves the pin low, and a set issued after a clear leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_rd | input | 1 | Read strobe for the current access |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid on the cycle after bus_rd |
| pad_func | output | 162 | Mode code per pin, pin p at bits 3p+2:3p |
| pad_oe | output | 54 | Output enable per pin |
| pad_out | output | 54 | Output latch level per pin |

## Verification
Every stored result passes through exactly one register: a mode or latch write is visible on the pad outputs one cycle after the edge that takes the write strobe, and read data is one cycle after the read strobe. The bench drives one access, waits for that single clock edge, then samples 1 ns after the edge. At that point it has applied the same access to its behavioural model, so each pad vector and each read word is compared in the cycle it is due. Because the model is updated and compared on every clock, a result that arrives a cycle early or late, or that changes when nothing was written, shows up as a mismatch.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    // Word width of the register port.
    localparam int WORD_W = 32;

    // Width of one pin mode code.
    localparam int FN_W = 3;

    // Mode codes seen by the pad multiplexer.
    typedef enum logic [FN_W-1:0] {
        MODE_INPUT  = 3'b000,
        MODE_OUTPUT = 3'b001,
        MODE_PERI0  = 3'b010,
        MODE_PERI1  = 3'b011,
        MODE_PERI2  = 3'b100,
        MODE_PERI3  = 3'b101,
        MODE_PERI4  = 3'b110,
        MODE_PERI5  = 3'b111
    } pin_mode_e;

    // Number of mode fields that fit into one word.
    localparam int FIELDS_PER_WORD = WORD_W / FN_W;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_mux_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int NUM_MODEW = 6,
    parameter int NUM_BANK  = 2
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_MODEW-1:0] mode_we,
    output logic [NUM_BANK-1:0]  set_we,
    output logic [NUM_BANK-1:0]  clr_we
);

    // Word map: mode words first, then set words, then clear words.
    localparam int SET_BASE = NUM_MODEW;
    localparam int CLR_BASE = NUM_MODEW + NUM_BANK;

    genvar gw;
    generate
        for (gw = 0; gw < NUM_MODEW; gw++) begin : g_mode_dec
            assign mode_we[gw] = bus_wr && (bus_addr == ADDR_W'(gw));
        end
        for (gw = 0; gw < NUM_BANK; gw++) begin : g_bank_dec
            assign set_we[gw] = bus_wr && (bus_addr == ADDR_W'(SET_BASE + gw));
            assign clr_we[gw] = bus_wr && (bus_addr == ADDR_W'(CLR_BASE + gw));
        end
    endgenerate

    // R11: a single access per cycle, so at most one strobe is active
    always_comb begin
        one_strobe_chk: assert ($onehot0({mode_we, set_we, clr_we}));
    end

endmodule

// File: rtl/gpio_mode_store.sv
module gpio_mode_store
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int NUM_MODEW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_MODEW-1:0]        mode_we,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NUM_PINS*FN_W-1:0]    mode_flat,
    output logic [NUM_MODEW*WORD_W-1:0] mode_words
);

    localparam int USED_BITS = FIELDS_PER_WORD * FN_W;

    logic [FN_W-1:0] mode_q [NUM_PINS];

    // Bits above the last field never reach storage.
    logic unused_hi;
    assign unused_hi = ^wdata[WORD_W-1:USED_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                mode_q[p] <= MODE_INPUT;
            end
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (mode_we[p / FIELDS_PER_WORD]) begin
                    mode_q[p] <= wdata[(p % FIELDS_PER_WORD)*FN_W +: FN_W];
                end
            end
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PINS; gp++) begin : g_flat
            assign mode_flat[gp*FN_W +: FN_W] = mode_q[gp];
        end
    endgenerate

    // Fields past the last pin and the top bits stay zero.
    always_comb begin
        mode_words = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            mode_words[(p / FIELDS_PER_WORD)*WORD_W + (p % FIELDS_PER_WORD)*FN_W +: FN_W] = mode_q[p];
        end
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|mode_we) |=> $stable(mode_flat));

    // R2
    mode_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we[0] |=> (mode_flat[FN_W-1:0] == $past(wdata[FN_W-1:0])));

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int NUM_BANK = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BANK-1:0] set_we,
    input  logic [NUM_BANK-1:0] clr_we,
    input  logic [WORD_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] level
);

    logic [NUM_PINS-1:0] set_mask;
    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] level_q;

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PINS; gp++) begin : g_mask
            assign set_mask[gp] = set_we[gp / WORD_W] && wdata[gp % WORD_W];
            assign clr_mask[gp] = clr_we[gp / WORD_W] && wdata[gp % WORD_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= (level_q | set_mask) & ~clr_mask;
        end
    end

    assign level = level_q;

    // R4
    set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_we) |=> ((level & $past(set_mask)) == $past(set_mask)));

    // R5
    clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_we) |=> ((level & $past(clr_mask)) == '0));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|set_we || |clr_we) |=> $stable(level));

endmodule

// File: rtl/gpio_pinmux_ctrl.sv
module gpio_pinmux_ctrl
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [NUM_PINS*FN_W-1:0] pad_func,
    output logic [NUM_PINS-1:0]      pad_oe,
    output logic [NUM_PINS-1:0]      pad_out
);

    localparam int NUM_MODEW = (NUM_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
    localparam int NUM_BANK  = (NUM_PINS + WORD_W - 1) / WORD_W;

    logic [NUM_MODEW-1:0]        mode_we;
    logic [NUM_BANK-1:0]         set_we;
    logic [NUM_BANK-1:0]         clr_we;
    logic [NUM_PINS*FN_W-1:0]    mode_flat;
    logic [NUM_MODEW*WORD_W-1:0] mode_words;
    logic [NUM_PINS-1:0]         level;
    logic [WORD_W-1:0]           rd_word;
    logic [WORD_W-1:0]           rdata_q;

    gpio_reg_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_MODEW(NUM_MODEW),
        .NUM_BANK (NUM_BANK)
    ) u_decode (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .mode_we (mode_we),
        .set_we  (set_we),
        .clr_we  (clr_we)
    );

    gpio_mode_store #(
        .NUM_PINS (NUM_PINS),
        .NUM_MODEW(NUM_MODEW)
    ) u_modes (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .wdata     (bus_wdata),
        .mode_flat (mode_flat),
        .mode_words(mode_words)
    );

    gpio_out_latch #(
        .NUM_PINS(NUM_PINS),
        .NUM_BANK(NUM_BANK)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_we(set_we),
        .clr_we(clr_we),
        .wdata (bus_wdata),
        .level (level)
    );

    // Only mode words hold readable state; every other address reads zero.
    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NUM_MODEW; w++) begin
            if (bus_addr == ADDR_W'(w)) begin
                rd_word = mode_words[w*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_word;
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PINS; gp++) begin : g_pad
            assign pad_oe[gp] = (mode_flat[gp*FN_W +: FN_W] == MODE_OUTPUT);
        end
    endgenerate

    assign pad_func  = mode_flat;
    assign pad_out   = level;
    assign bus_rdata = rdata_q;

    // R6 R9
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr >= ADDR_W'(NUM_MODEW))) |=> (bus_rdata == '0));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/gpio_pinmux_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pinmux_ctrl_bench;

    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP*3-1:0] pad_func;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;

    int n_tot = 0;
    int n_bad = 0;

    int m_func [NP];
    bit m_lat  [NP];

    always #2.5 clk = ~clk;

    gpio_pinmux_ctrl u_gpio_pinmux_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_func (pad_func),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = '0;
        if (a < 6) begin
            for (int k = 0; k < 10; k++) begin
                int p = a*10 + k;
                if (p < NP) r[3*k +: 3] = m_func[p][2:0];
            end
        end
        return r;
    endfunction

    function automatic void m_write(int a, logic [31:0] d);
        if (a < 6) begin
            for (int k = 0; k < 10; k++) begin
                int p = a*10 + k;
                if (p < NP) m_func[p] = int'(d[3*k +: 3]);
            end
        end else if (a < 10) begin
            for (int b = 0; b < 32; b++) begin
                int p = ((a - 6) % 2)*32 + b;
                if (p < NP && d[b]) m_lat[p] = (a < 8);
            end
        end
    endfunction

    task automatic cmp_pads(string tag);
        logic [NP*3-1:0] ef;
        logic [NP-1:0]   eo;
        logic [NP-1:0]   el;
        for (int p = 0; p < NP; p++) begin
            ef[p*3 +: 3] = m_func[p][2:0];
            eo[p] = (m_func[p] == 1);
            el[p] = m_lat[p];
        end
        check({tag, " R3 pad_func"}, 256'(pad_func), 256'(ef));
        check({tag, " R3 pad_oe"},   256'(pad_oe),   256'(eo));
        check({tag, " R7 pad_out"},  256'(pad_out),  256'(el));
    endtask

    // One access per clock; model updated and compared 1 ns after the edge.
    task automatic op(bit wr, bit rd, int a, logic [31:0] d, string tag);
        logic [31:0] er;
        bus_wr = wr; bus_rd = rd; bus_addr = 4'(a); bus_wdata = d;
        er = m_read(a);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        if (wr) m_write(a, d);
        cmp_pads(tag);
        if (rd) check({tag, " R10 rdata"}, 256'(bus_rdata), 256'(er));
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        op(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(int a, string tag);
        op(1'b0, 1'b1, a, 32'h0, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_func[p] = 0;
            m_lat[p]  = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        cmp_pads("R1 reset");
        check("R1 oe zero", 256'(pad_oe), 256'(0));
        for (int a = 0; a < 10; a++) rd(a, "R1 R6 reset read");

        // R2 R3: pin 0 output, pin 1 alt 010, pin 9 alt 111
        wr(0, 32'h3800_0011, "R2 mode word0");
        rd(0, "R2 readback word0");
        check("R3 pin1 code 010", 256'(pad_func[5:3]), 256'(3'b010));
        check("R3 pin1 oe low", 256'(pad_oe[1]), 256'(0));

        // R4: raise pins 0 and 1
        wr(6, 32'h0000_0003, "R4 set low bank");
        check("R4 pin0 high", 256'(pad_out[0]), 256'(1));
        wr(6, 32'h0000_0000, "R4 zero set no effect");

        // R11: clear after set gives low, set after clear gives high
        wr(8, 32'h0000_0001, "R11 clear after set");
        check("R11 pin0 low", 256'(pad_out[0]), 256'(0));
        wr(6, 32'h0000_0001, "R11 set after clear");
        check("R11 pin0 high", 256'(pad_out[0]), 256'(1));

        // R5: zero clear no effect
        wr(8, 32'h0000_0000, "R5 zero clear no effect");
        check("R5 pin0 still high", 256'(pad_out[0]), 256'(1));

        // R6: set and clear words read zero
        rd(6, "R6 set read"); rd(7, "R6 set read");
        rd(8, "R6 clear read"); rd(9, "R6 clear read");

        // R7: latch retained through input mode
        wr(0, 32'h0000_0010, "R7 pin0 to input");
        check("R7 pin0 oe off", 256'(pad_oe[0]), 256'(0));
        check("R7 pin0 latch kept", 256'(pad_out[0]), 256'(1));
        wr(0, 32'h0000_0011, "R7 pin0 back to output");
        check("R7 pin0 oe on", 256'(pad_oe[0]), 256'(1));

        // R8: top mode word and upper bank bits
        wr(5, 32'hFFFF_FFFF, "R8 word5 all ones");
        rd(5, "R8 word5 readback");
        check("R8 word5 value", 256'(bus_rdata), 256'(32'h0000_0FFF));
        wr(1, 32'hFFFF_FFFF, "R8 word1 top bits");
        rd(1, "R8 word1 readback");
        check("R8 word1 value", 256'(bus_rdata), 256'(32'h3FFF_FFFF));
        wr(7, 32'hFFFF_FFFF, "R8 set high bank");
        check("R8 pin53 high", 256'(pad_out[53]), 256'(1));
        wr(9, 32'hFFC0_0000, "R8 unused clear bits");
        check("R8 pin53 still high", 256'(pad_out[53]), 256'(1));
        wr(5, 32'h0000_0200, "R3 pin53 output");
        check("R3 pin53 oe", 256'(pad_oe[53]), 256'(1));

        // R9: out-of-range addresses
        wr(10, 32'hFFFF_FFFF, "R9 write addr10");
        wr(15, 32'hFFFF_FFFF, "R9 write addr15");
        rd(12, "R9 read addr12");
        check("R9 read zero", 256'(bus_rdata), 256'(0));

        // Mixed pattern, model compared every clock (R2 R4 R5 R10)
        for (int i = 0; i < 400; i++) begin
            int a = int'($urandom_range(0, 11));
            logic [31:0] d = $urandom;
            case ($urandom_range(0, 2))
                0: wr(a, d, "R2 R4 R5 mixed write");
                1: rd(a, "R10 mixed read");
                default: op(1'b0, 1'b0, 0, 32'h0, "R7 idle");
            endcase
        end

        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule